// File: doc/BRIEF.md
# Dual-Port Semaphore Flag Bank

This block holds eight ownership flags that two independent requesters, a left side and a right side, use to take turns on a shared resource. Each side has its own synchronous access bus. That bus carries an access select, a memory enable (which must be low for a flag access), a write strobe, a 3-bit flag index, a 9-bit write word and a registered 9-bit read word. A side asks for a flag by writing 0 in bit 0 of the write word and gives the flag back by writing 1.

The rules for ownership are fixed. If both sides ask for the same free flag in the same clock cycle, the left side gets it. A side that asks for a flag it cannot have yet keeps its request open, and it takes the flag on the same clock edge that the owner gives it up. A give-back from a side that does not own the flag does nothing.

A read returns the ownership state as seen by the reading side. The value is 0 when that side owns the flag and 1 otherwise, and the same value is copied onto every bit of the read word.

Top module: `sem_arbiter_top`

## Requirements
- R1: After reset every flag is free, and both read words are 9'h1FF until the first read captures a new value.
- R2: A side makes a flag access only in a cycle where its select is 1 and its memory enable is 0. In any other cycle, that side's inputs change no flag and do not change its read word.
- R3: The 3-bit index picks one of eight flags. An access to one flag never changes the state of any other flag.
- R4: A write uses only bit 0 of the write word: 0 asks for the flag and 1 gives it back. Bits 8:1 are ignored.
- R5: A read (write strobe 0) is captured at the clock edge. After that edge the read word is 9'h000 if the reading side owns the flag and 9'h1FF otherwise. The word keeps that value until the side's next read.
- R6: A request on a free flag grants it at that edge, so a read issued in the next cycle already sees the new owner.
- R7: When both sides request the same free flag in the same cycle, the left side becomes the owner and the right side's request stays open.
- R8: An open request is granted on the same edge at which the owner's give-back takes effect, with no further write from the waiting side.
- R9: A give-back from a side that does not own the flag is ignored. The owner keeps the flag, and an open request from the side that wrote stays open.
- R10: The right side has the same owner and waiting behaviour as the left side. It can own a flag while the left side waits.
- R11: No flag is ever owned by both sides at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every transfer happens on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| l_sel | input | 1 | Left side flag access select, active high |
| l_mem_en | input | 1 | Left side memory enable; must be 0 for a flag access |
| l_wr | input | 1 | Left side write strobe (1 write, 0 read) |
| l_addr | input | 3 | Left side flag index |
| l_wdata | input | 9 | Left side write word; only bit 0 is used |
| l_rdata | output | 9 | Left side registered read word |
| r_sel | input | 1 | Right side flag access select, active high |
| r_mem_en | input | 1 | Right side memory enable; must be 0 for a flag access |
| r_wr | input | 1 | Right side write strobe (1 write, 0 read) |
| r_addr | input | 3 | Right side flag index |
| r_wdata | input | 9 | Right side write word; only bit 0 is used |
| r_rdata | output | 9 | Right side registered read word |

## Verification
A write, whether it asks for a flag or gives one back, changes ownership at the edge that samples it. A read is captured one edge later, so its result appears on the read word just after that second edge. A grant to a waiting side is due at the same edge as the owner's give-back, and it becomes visible through a read one cycle after that. The bench drives each step on the falling edge and compares the read words a nanosecond after the rising edge that captures the read. Each write step is followed by a read step, which places every check in the cycle where the result is first valid.

// File: rtl/sem_pkg.sv
package sem_pkg;

  // State of one flag: owner bits and open-request bits for each side
  typedef struct packed {
    logic own_l;
    logic own_r;
    logic pend_l;
    logic pend_r;
  } flag_t;

  localparam flag_t FLAG_FREE = '{own_l: 1'b0, own_r: 1'b0, pend_l: 1'b0, pend_r: 1'b0};

  // Value seen by a reader: 0 when it owns the flag, 1 otherwise
  function automatic logic sem_status_bit(input logic owned);
    return ~owned;
  endfunction

  // Bit 0 of the write word: 0 asks for the flag, 1 gives it back
  function automatic logic sem_is_request(input logic wbit0);
    return ~wbit0;
  endfunction

  // Next state of one flag from this cycle's decoded requests and give-backs
  function automatic flag_t sem_next(input flag_t cur,
                                     input logic req_l, input logic rel_l,
                                     input logic req_r, input logic rel_r);
    flag_t nx;
    nx        = cur;
    nx.pend_l = cur.pend_l | (req_l & ~cur.own_l);
    nx.pend_r = cur.pend_r | (req_r & ~cur.own_r);
    if (cur.own_l && rel_l) nx.own_l = 1'b0;
    if (cur.own_r && rel_r) nx.own_r = 1'b0;
    if (!nx.own_l && !nx.own_r) begin
      if (nx.pend_l)      nx.own_l = 1'b1;   // left wins a tie
      else if (nx.pend_r) nx.own_r = 1'b1;
    end
    if (nx.own_l) nx.pend_l = 1'b0;
    if (nx.own_r) nx.pend_r = 1'b0;
    return nx;
  endfunction

endpackage

// File: rtl/sem_port_if.sv
module sem_port_if
  import sem_pkg::*;
#(
  parameter int NUM_FLAGS = 8,
  parameter int ADDR_W    = $clog2(NUM_FLAGS),
  parameter int DATA_W    = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sel,
  input  logic                 mem_en,
  input  logic                 wr,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [NUM_FLAGS-1:0] own,
  output logic [NUM_FLAGS-1:0] req_vec,
  output logic [NUM_FLAGS-1:0] rel_vec,
  output logic                 rd_evt,
  output logic [DATA_W-1:0]    rdata
);

  logic access;
  logic wr_evt;
  logic want;
  logic [NUM_FLAGS-1:0] hit;
  logic unused_wdata_hi;

  assign access          = sel & ~mem_en;
  assign wr_evt          = access & wr;
  assign rd_evt          = access & ~wr;
  assign want            = sem_is_request(wdata[0]);
  assign unused_wdata_hi = ^wdata[DATA_W-1:1];

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_dec
    assign hit[i]     = (addr == ADDR_W'(i));
    assign req_vec[i] = wr_evt & hit[i] & want;
    assign rel_vec[i] = wr_evt & hit[i] & ~want;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rdata <= '1;
    else if (rd_evt) rdata <= {DATA_W{sem_status_bit(own[addr])}};
  end

endmodule

// File: rtl/sem_flag_cell.sv
module sem_flag_cell
  import sem_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_l,
  input  logic rel_l,
  input  logic req_r,
  input  logic rel_r,
  output logic own_l,
  output logic own_r,
  output logic pend_l,
  output logic pend_r
);

  flag_t cur_q;
  flag_t nxt;

  always_comb nxt = sem_next(cur_q, req_l, rel_l, req_r, rel_r);

  always_ff @(posedge clk) begin
    if (!rst_n) cur_q <= FLAG_FREE;
    else        cur_q <= nxt;
  end

  assign own_l  = cur_q.own_l;
  assign own_r  = cur_q.own_r;
  assign pend_l = cur_q.pend_l;
  assign pend_r = cur_q.pend_r;

endmodule

// File: rtl/sem_arbiter_top.sv
module sem_arbiter_top #(
  parameter int NUM_FLAGS = 8,
  parameter int ADDR_W    = $clog2(NUM_FLAGS),
  parameter int DATA_W    = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_sel,
  input  logic              l_mem_en,
  input  logic              l_wr,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              r_sel,
  input  logic              r_mem_en,
  input  logic              r_wr,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata
);

  // Internal events brought out for the checker
  logic [NUM_FLAGS-1:0] req_l, rel_l, req_r, rel_r;
  logic [NUM_FLAGS-1:0] own_l, own_r, pend_l, pend_r;
  logic                 rd_l, rd_r;

  sem_port_if #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_left (
    .clk(clk), .rst_n(rst_n), .sel(l_sel), .mem_en(l_mem_en), .wr(l_wr),
    .addr(l_addr), .wdata(l_wdata), .own(own_l),
    .req_vec(req_l), .rel_vec(rel_l), .rd_evt(rd_l), .rdata(l_rdata)
  );

  sem_port_if #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_right (
    .clk(clk), .rst_n(rst_n), .sel(r_sel), .mem_en(r_mem_en), .wr(r_wr),
    .addr(r_addr), .wdata(r_wdata), .own(own_r),
    .req_vec(req_r), .rel_vec(rel_r), .rd_evt(rd_r), .rdata(r_rdata)
  );

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    sem_flag_cell u_cell (
      .clk(clk), .rst_n(rst_n),
      .req_l(req_l[i]), .rel_l(rel_l[i]), .req_r(req_r[i]), .rel_r(rel_r[i]),
      .own_l(own_l[i]), .own_r(own_r[i]), .pend_l(pend_l[i]), .pend_r(pend_r[i])
    );
  end

endmodule

// File: rtl/sem_arbiter_checker.sv
module sem_arbiter_checker #(
  parameter int NUM_FLAGS = 8,
  parameter int DATA_W    = 9
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 l_sel,
  input logic                 l_mem_en,
  input logic                 r_sel,
  input logic                 r_mem_en,
  input logic [NUM_FLAGS-1:0] req_l,
  input logic [NUM_FLAGS-1:0] rel_l,
  input logic [NUM_FLAGS-1:0] req_r,
  input logic [NUM_FLAGS-1:0] rel_r,
  input logic [NUM_FLAGS-1:0] own_l,
  input logic [NUM_FLAGS-1:0] own_r,
  input logic [NUM_FLAGS-1:0] pend_l,
  input logic [NUM_FLAGS-1:0] pend_r,
  input logic [DATA_W-1:0]    l_rdata,
  input logic [DATA_W-1:0]    r_rdata
);

  assert_single_owner_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (own_l & own_r) == '0);

  assert_read_uniform_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (l_rdata == '0 || l_rdata == '1) && (r_rdata == '0 || r_rdata == '1));

  assert_idle_no_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!(l_sel && !l_mem_en) && !(r_sel && !r_mem_en)) |=>
      ($stable(own_l) && $stable(own_r) && $stable(l_rdata) && $stable(r_rdata)));

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_chk
    assert_grant_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_l[i] && !own_l[i] && !own_r[i]) |=> own_l[i]);

    assert_tie_left_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_l[i] && req_r[i] && !own_l[i] && !own_r[i]) |=> (own_l[i] && pend_r[i]));

    assert_handover_right_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (own_l[i] && rel_l[i] && pend_r[i]) |=> own_r[i]);

    assert_handover_left_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (own_r[i] && rel_r[i] && pend_l[i]) |=> own_l[i]);

    assert_foreign_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (own_l[i] && rel_r[i] && !rel_l[i]) |=> own_l[i]);
  end

endmodule

bind sem_arbiter_top sem_arbiter_checker #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .l_sel(l_sel), .l_mem_en(l_mem_en), .r_sel(r_sel), .r_mem_en(r_mem_en),
  .req_l(req_l), .rel_l(rel_l), .req_r(req_r), .rel_r(rel_r),
  .own_l(own_l), .own_r(own_r), .pend_l(pend_l), .pend_r(pend_r),
  .l_rdata(l_rdata), .r_rdata(r_rdata)
);

// File: tb/sim_sem_arbiter_top.sv
`timescale 1ns/1ps
module sim_sem_arbiter_top;

  typedef struct packed {
    logic       s;
    logic       m;
    logic       w;
    logic [2:0] a;
    logic [8:0] d;
  } port_t;

  typedef struct packed {
    port_t      l;
    port_t      r;
    logic       cl;   // check left read word
    logic       el;   // expected left bit
    logic       cr;
    logic       er;
    logic [3:0] req;  // requirement number for messages
  } vec_t;

  function automatic port_t p_idle();
    return '{s: 1'b0, m: 1'b0, w: 1'b0, a: 3'd0, d: 9'd0};
  endfunction
  function automatic port_t p_rd(input int a);
    return '{s: 1'b1, m: 1'b0, w: 1'b0, a: 3'(a), d: 9'd0};
  endfunction
  // request with noise in the ignored upper bits
  function automatic port_t p_ask(input int a);
    return '{s: 1'b1, m: 1'b0, w: 1'b1, a: 3'(a), d: 9'h1FE};
  endfunction
  function automatic port_t p_give(input int a);
    return '{s: 1'b1, m: 1'b0, w: 1'b1, a: 3'(a), d: 9'h001};
  endfunction
  function automatic port_t p_blocked(input int a);
    return '{s: 1'b1, m: 1'b1, w: 1'b1, a: 3'(a), d: 9'h000};
  endfunction
  function automatic port_t p_unsel(input int a);
    return '{s: 1'b0, m: 1'b0, w: 1'b1, a: 3'(a), d: 9'h000};
  endfunction

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{p_rd(0),      p_rd(0),      1'b1, 1'b1, 1'b1, 1'b1, 4'd1},  // R1 free after reset
    '{p_ask(0),     p_idle(),     1'b0, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 ask f0, noisy upper bits
    '{p_rd(0),      p_rd(0),      1'b1, 1'b0, 1'b1, 1'b1, 4'd6},  // R6 R5 left owns f0
    '{p_idle(),     p_ask(0),     1'b0, 1'b0, 1'b0, 1'b0, 4'd8},  // R8 right waits
    '{p_idle(),     p_rd(0),      1'b0, 1'b0, 1'b1, 1'b1, 4'd8},  // R8 still left's
    '{p_give(0),    p_idle(),     1'b0, 1'b0, 1'b0, 1'b0, 4'd8},  // R8 give back
    '{p_rd(0),      p_rd(0),      1'b1, 1'b1, 1'b1, 1'b0, 4'd10}, // R10 R8 right owns
    '{p_ask(1),     p_ask(1),     1'b0, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 tie
    '{p_rd(1),      p_rd(1),      1'b1, 1'b0, 1'b1, 1'b1, 4'd7},  // R7 left wins
    '{p_idle(),     p_give(1),    1'b0, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 foreign give-back
    '{p_rd(1),      p_rd(1),      1'b1, 1'b0, 1'b1, 1'b1, 4'd9},  // R9 owner kept
    '{p_give(1),    p_idle(),     1'b0, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 wait survived
    '{p_rd(1),      p_rd(1),      1'b1, 1'b1, 1'b1, 1'b0, 4'd9},  // R9 R8 right got f1
    '{p_blocked(2), p_unsel(2),   1'b1, 1'b1, 1'b1, 1'b0, 4'd2},  // R2 words hold
    '{p_rd(2),      p_rd(2),      1'b1, 1'b1, 1'b1, 1'b1, 4'd2},  // R2 f2 still free
    '{p_unsel(2),   p_rd(2),      1'b0, 1'b0, 1'b1, 1'b1, 4'd2},  // R2 unselected write
    '{p_rd(2),      p_rd(2),      1'b1, 1'b1, 1'b1, 1'b1, 4'd2},  // R2 f2 still free
    '{p_ask(2),     p_ask(7),     1'b0, 1'b0, 1'b0, 1'b0, 4'd3},  // R3 two flags
    '{p_rd(7),      p_rd(2),      1'b1, 1'b1, 1'b1, 1'b1, 4'd3},  // R3 cross reads
    '{p_rd(2),      p_rd(7),      1'b1, 1'b0, 1'b1, 1'b0, 4'd3}   // R3 own reads
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  port_t      lp, rp;
  logic [8:0] l_rdata, r_rdata;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  sem_arbiter_top u0 (
    .clk(clk), .rst_n(rst_n),
    .l_sel(lp.s), .l_mem_en(lp.m), .l_wr(lp.w), .l_addr(lp.a), .l_wdata(lp.d), .l_rdata(l_rdata),
    .r_sel(rp.s), .r_mem_en(rp.m), .r_wr(rp.w), .r_addr(rp.a), .r_wdata(rp.d), .r_rdata(r_rdata)
  );

  task automatic check(input string what, input int req, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(input port_t l, input port_t r);
    @(negedge clk);
    lp = l;
    rp = r;
    @(posedge clk);
    #1;
  endtask

  initial begin
    lp = p_idle();
    rp = p_idle();
    repeat (3) @(posedge clk);
    #1;
    check("reset left word", 1, l_rdata, 9'h1FF);   // R1
    check("reset right word", 1, r_rdata, 9'h1FF);  // R1
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].l, VECS[i].r);
      if (VECS[i].cl) check($sformatf("vec %0d left", i), int'(VECS[i].req), l_rdata, {9{VECS[i].el}});
      if (VECS[i].cr) check($sformatf("vec %0d right", i), int'(VECS[i].req), r_rdata, {9{VECS[i].er}});
    end

    // R1: reset in the middle of ownership frees the flags
    step(p_ask(5), p_ask(6));
    @(negedge clk);
    rst_n = 1'b0;
    lp = p_idle();
    rp = p_idle();
    @(posedge clk);
    #1;
    check("word after mid reset left", 1, l_rdata, 9'h1FF);
    check("word after mid reset right", 1, r_rdata, 9'h1FF);
    @(negedge clk);
    rst_n = 1'b1;
    step(p_rd(5), p_rd(6));
    check("f5 free after reset", 1, l_rdata, 9'h1FF);
    check("f6 free after reset", 1, r_rdata, 9'h1FF);

    // R10: right asks alone on a free flag, left waits, then handover
    step(p_idle(), p_ask(4));
    step(p_ask(4), p_rd(4));
    check("right owns f4", 10, r_rdata, 9'h000);
    step(p_rd(4), p_give(4));
    check("left waiting f4", 10, l_rdata, 9'h1FF);
    step(p_rd(4), p_rd(4));
    check("left got f4", 10, l_rdata, 9'h000);
    check("right lost f4", 10, r_rdata, 9'h1FF);

    // R6: read issued right after the write sees the grant
    step(p_ask(3), p_idle());
    step(p_rd(3), p_idle());
    check("grant visible next cycle", 6, l_rdata, 9'h000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R0 watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule